// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Timing Monitor

This block watches the registered command bus of a four-bank DDR SDRAM. On every rising clock edge it samples clock enable, the four active-low command strobes, address bit 10 and the bank address. It turns them into a command code, keeps an open/closed state for each bank and checks each command against the row, precharge, refresh and mode-register timing rules. A command that breaks a rule produces a one-cycle violation pulse and a reason code. The monitor is passive: a flagged command is treated as rejected and changes no tracked state.

All timing limits are parameters in clock cycles. The two precharge-related limits are given in picoseconds together with the clock period and rounded up to whole cycles. The combined write-recovery-plus-precharge count is formed by rounding each term up on its own and then adding them. With a 7.5 ns clock, 15 ns recovery and 20 ns precharge, this gives 2 + 3 = 5 cycles. Auto-precharge reads and writes lock their bank for a window that depends on the burst length and on these counts.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: When clock enable is high in the current and the previous sample, {cs_n,ras_n,cas_n,we_n} decode to a command code: 0000 → 2 (mode set), or 3 (extended mode set) when bank address is 1; 0011 → 4 (activate); 0101 → 5 (read), or 6 with a10 high; 0100 → 7 (write), or 8 with a10 high; 0010 → 9 (precharge one bank), or 10 with a10 high (all banks, bank address ignored); 0110 → 11 (burst stop); 0001 → 12 (auto refresh); 0111 → 0 (no-op); cs_n high → 1 (deselect). If clock enable is low in either sample, the code is 13, and nothing is checked or changed.
- R2: cmd_o, viol_o, reason_o and bank_active_o update one clock after the sampling edge. viol_o is high for exactly the cycle of an offending command. reason_o takes that command's reason and holds it until the next violation. Reset clears all outputs to 0.
- R3: A flagged command changes neither bank state nor any timer.
- R4: If a command breaks several rules, reason_o reports the smallest code.
- R5: A read or write to a closed bank gives reason 4. An activate to an open bank gives reason 5.
- R6: A read or write sooner than T_RCD cycles after its bank's activate gives reason 6. An activate sooner than T_RRD cycles after any accepted activate gives reason 9.
- R7: A precharge (single or all) that covers an open bank sooner than T_RAS cycles after that bank's activate gives reason 7. An activate sooner than T_RC cycles after the same bank's activate gives reason 8.
- R8: A precharge of an open bank closes it and locks it for ceil(TRP_PS/TCK_PS) cycles. While locked, an activate, read, write or precharge that targets the bank gives reason 3. The all-bank precharge closes every open bank.
- R9: A read with auto-precharge in cycle n closes its bank. Any such command to that bank before cycle n + BURST_LEN/2 + ceil(TRP_PS/TCK_PS) gives reason 3.
- R10: A write with auto-precharge in cycle n closes its bank. Any such command to that bank before cycle n + BURST_LEN/2 + 1 + ceil(TDPL_PS/TCK_PS) + ceil(TRP_PS/TCK_PS) gives reason 3.
- R11: An auto refresh when any bank is open or locked gives reason 11. After an accepted refresh, any command other than no-op, deselect or code 13 within T_RFC cycles gives reason 1.
- R12: A mode or extended mode set when any bank is open or locked gives reason 10. After an accepted one, any command other than no-op, deselect or code 13 within T_MRD cycles gives reason 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge sampling |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| a10_i | input | 1 | Address bit 10 (auto-precharge / all banks) |
| ba_i | input | BA_W | Bank address |
| cmd_o | output | 4 | Decoded command code of the previous sample |
| bank_active_o | output | NUM_BANKS | Open state of each bank |
| viol_o | output | 1 | One-cycle pulse for a rule-breaking command |
| reason_o | output | 4 | Reason of the latest violation |

## Verification
Every result is due one rising edge after the edge that samples its command. At that point the decoded code, the violation pulse, the held reason and the bank state must all show the outcome of that command. The driver sets the pins on the falling edge and queues the expected outputs at the same moment. The monitor compares them 2 ns after the next rising edge, so each comparison sees the result of exactly one command. Timing windows are checked at their last illegal cycle and their first legal cycle: for example, the write auto-precharge lockout is probed 7 cycles after the write and the bank is reopened 8 cycles after it.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_EMRS  = 4'd3,
    CMD_ACT   = 4'd4,
    CMD_RD    = 4'd5,
    CMD_RDA   = 4'd6,
    CMD_WR    = 4'd7,
    CMD_WRA   = 4'd8,
    CMD_PRE   = 4'd9,
    CMD_PREA  = 4'd10,
    CMD_BST   = 4'd11,
    CMD_REF   = 4'd12,
    CMD_CKE   = 4'd13
  } cmd_e;

  // reason codes, smaller value = higher priority
  localparam logic [3:0] RSN_RFC    = 4'd1;
  localparam logic [3:0] RSN_MRD    = 4'd2;
  localparam logic [3:0] RSN_LOCK   = 4'd3;
  localparam logic [3:0] RSN_IDLE   = 4'd4;
  localparam logic [3:0] RSN_OPEN   = 4'd5;
  localparam logic [3:0] RSN_RCD    = 4'd6;
  localparam logic [3:0] RSN_RAS    = 4'd7;
  localparam logic [3:0] RSN_RC     = 4'd8;
  localparam logic [3:0] RSN_RRD    = 4'd9;
  localparam logic [3:0] RSN_MRSRDY = 4'd10;
  localparam logic [3:0] RSN_REFRDY = 4'd11;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_prev,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            a10,
  input  logic [BA_W-1:0] ba,
  output cmd_e            cmd
);

  always_comb begin
    if (!(cke_prev && cke)) begin
      cmd = CMD_CKE;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = (ba == BA_W'(1)) ? CMD_EMRS : CMD_MRS;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
        3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b110:  cmd = CMD_BST;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer
  import ddr_mon_pkg::*;
#(
  parameter int CW       = 4,
  parameter int T_RCD    = 3,
  parameter int T_RAS    = 6,
  parameter int T_RC     = 8,
  parameter int T_RP     = 3,
  parameter int LOCK_RDA = 5,
  parameter int LOCK_WRA = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  cmd_e        cmd,
  input  logic        hit,
  input  logic        apply,
  output logic        active,
  output logic        ready,
  output logic [15:0] flags
);

  logic [CW-1:0] rcd_cnt, ras_cnt, rc_cnt, lock_cnt;
  logic is_act, is_rw, is_pre;

  assign is_act = (cmd == CMD_ACT);
  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_RDA) || (cmd == CMD_WR) || (cmd == CMD_WRA);
  assign is_pre = (cmd == CMD_PRE) || (cmd == CMD_PREA);
  assign ready  = !active && (lock_cnt == '0);

  always_comb begin
    flags = '0;
    flags[RSN_LOCK] = hit && (is_act || is_rw || is_pre) && (lock_cnt != '0);
    flags[RSN_IDLE] = hit && is_rw && !active;
    flags[RSN_OPEN] = hit && is_act && active;
    flags[RSN_RCD]  = hit && is_rw && active && (rcd_cnt != '0);
    flags[RSN_RAS]  = hit && is_pre && active && (ras_cnt != '0);
    flags[RSN_RC]   = hit && is_act && (rc_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      rcd_cnt  <= '0;
      ras_cnt  <= '0;
      rc_cnt   <= '0;
      lock_cnt <= '0;
    end else begin
      rcd_cnt  <= rcd_cnt  - CW'(rcd_cnt  != '0);
      ras_cnt  <= ras_cnt  - CW'(ras_cnt  != '0);
      rc_cnt   <= rc_cnt   - CW'(rc_cnt   != '0);
      lock_cnt <= lock_cnt - CW'(lock_cnt != '0);
      if (apply && hit) begin
        case (cmd)
          CMD_ACT: begin
            active  <= 1'b1;
            rcd_cnt <= CW'(T_RCD - 1);
            ras_cnt <= CW'(T_RAS - 1);
            rc_cnt  <= CW'(T_RC - 1);
          end
          CMD_RDA: begin
            active   <= 1'b0;
            lock_cnt <= CW'(LOCK_RDA - 1);
          end
          CMD_WRA: begin
            active   <= 1'b0;
            lock_cnt <= CW'(LOCK_WRA - 1);
          end
          CMD_PRE, CMD_PREA: begin
            if (active) begin
              active   <= 1'b0;
              lock_cnt <= CW'(T_RP - 1);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int TCK_PS    = 7500,
  parameter int TRP_PS    = 20000,
  parameter int TDPL_PS   = 15000,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 8,
  parameter int T_RFC     = 10,
  parameter int T_MRD     = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke_i,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic                 a10_i,
  input  logic [BA_W-1:0]      ba_i,
  output logic [3:0]           cmd_o,
  output logic [NUM_BANKS-1:0] bank_active_o,
  output logic                 viol_o,
  output logic [3:0]           reason_o
);

  localparam int T_RP     = ceil_div(TRP_PS, TCK_PS);
  localparam int T_DPL    = ceil_div(TDPL_PS, TCK_PS);
  localparam int T_DAL    = T_DPL + T_RP;
  localparam int LOCK_RDA = BURST_LEN / 2 + T_RP;
  localparam int LOCK_WRA = BURST_LEN / 2 + 1 + T_DAL;
  localparam int MAXC     = max2(max2(max2(T_RC, T_RAS), max2(T_RCD, LOCK_WRA)),
                                 max2(max2(LOCK_RDA, T_RFC), max2(T_MRD, T_RRD)));
  localparam int CW       = $clog2(MAXC + 1);

  logic          cke_prev;
  cmd_e          cmd;
  logic [CW-1:0] rrd_cnt, mrd_cnt, rfc_cnt;
  logic [NUM_BANKS-1:0] bank_ready, bank_hit;
  logic [15:0]   bflags [NUM_BANKS];
  logic [15:0]   gflags, vec;
  logic [3:0]    code;
  logic          apply, all_ready, busy_cmd, bank_cmd;

  ddr_cmd_decode #(.BA_W(BA_W)) u_dec (
    .cke_prev (cke_prev),
    .cke      (cke_i),
    .cs_n     (cs_n_i),
    .ras_n    (ras_n_i),
    .cas_n    (cas_n_i),
    .we_n     (we_n_i),
    .a10      (a10_i),
    .ba       (ba_i),
    .cmd      (cmd)
  );

  assign bank_cmd = (cmd == CMD_ACT) || (cmd == CMD_RD) || (cmd == CMD_RDA) ||
                    (cmd == CMD_WR) || (cmd == CMD_WRA) || (cmd == CMD_PRE);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
      assign bank_hit[gi] = (bank_cmd && (ba_i == BA_W'(gi))) || (cmd == CMD_PREA);
      ddr_bank_timer #(
        .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
        .LOCK_RDA(LOCK_RDA), .LOCK_WRA(LOCK_WRA)
      ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .hit    (bank_hit[gi]),
        .apply  (apply),
        .active (bank_active_o[gi]),
        .ready  (bank_ready[gi]),
        .flags  (bflags[gi])
      );
    end
  endgenerate

  assign all_ready = &bank_ready;
  assign busy_cmd  = (cmd != CMD_NOP) && (cmd != CMD_DESEL) && (cmd != CMD_CKE);

  always_comb begin
    gflags = '0;
    gflags[RSN_RFC]    = busy_cmd && (rfc_cnt != '0);
    gflags[RSN_MRD]    = busy_cmd && (mrd_cnt != '0);
    gflags[RSN_RRD]    = (cmd == CMD_ACT) && (rrd_cnt != '0);
    gflags[RSN_MRSRDY] = ((cmd == CMD_MRS) || (cmd == CMD_EMRS)) && !all_ready;
    gflags[RSN_REFRDY] = (cmd == CMD_REF) && !all_ready;
  end

  always_comb begin
    vec = gflags;
    for (int b = 0; b < NUM_BANKS; b++) vec = vec | bflags[b];
  end

  always_comb begin
    code = 4'd0;
    for (int k = 15; k >= 0; k--) begin
      if (vec[k]) code = 4'(k);
    end
  end

  assign apply = (vec == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_prev <= 1'b0;
      rrd_cnt  <= '0;
      mrd_cnt  <= '0;
      rfc_cnt  <= '0;
      cmd_o    <= 4'd0;
      viol_o   <= 1'b0;
      reason_o <= 4'd0;
    end else begin
      cke_prev <= cke_i;
      rrd_cnt  <= rrd_cnt - CW'(rrd_cnt != '0);
      mrd_cnt  <= mrd_cnt - CW'(mrd_cnt != '0);
      rfc_cnt  <= rfc_cnt - CW'(rfc_cnt != '0);
      if (apply) begin
        case (cmd)
          CMD_ACT:           rrd_cnt <= CW'(T_RRD - 1);
          CMD_REF:           rfc_cnt <= CW'(T_RFC - 1);
          CMD_MRS, CMD_EMRS: mrd_cnt <= CW'(T_MRD - 1);
          default: ;
        endcase
      end
      cmd_o  <= cmd;
      viol_o <= !apply;
      if (!apply) reason_o <= code;
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int T_RRD     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [BA_W-1:0]      ba_i,
  input logic [3:0]           cmd_o,
  input logic [NUM_BANKS-1:0] bank_active_o,
  input logic                 viol_o,
  input logic [3:0]           reason_o
);

  logic [BA_W-1:0] ba_q;
  always_ff @(posedge clk) ba_q <= ba_i;

  assert_reason_set_R2: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> (reason_o != 4'd0));

  assert_reason_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !viol_o |-> $stable(reason_o));

  assert_flag_no_effect_R3: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> (bank_active_o == $past(bank_active_o)));

  assert_act_opens_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_ACT && !viol_o) |-> bank_active_o[ba_q]);

  assert_ref_all_closed_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_REF && !viol_o) |-> (bank_active_o == '0));

  generate
    if (T_RRD > 1) begin : g_rrd
      assert_act_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ACT && !viol_o) |=> !(cmd_o == CMD_ACT && !viol_o));
    end
  endgenerate

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(
  .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .T_RRD(T_RRD)
) u_chk (.*);

// File: tb/sim_ddr_cmd_monitor.sv
module sim_ddr_cmd_monitor;
  import ddr_mon_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke_i = 1'b1, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1, a10_i = 1'b0;
  logic [1:0] ba_i = 2'd0;
  logic [3:0] cmd_o, reason_o;
  logic [3:0] bank_active_o;
  logic viol_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [3:0] bk = 4'b0000;
  logic [3:0] last_r = 4'd0;

  logic [3:0] q_cmd[$];
  logic       q_v[$];
  logic [3:0] q_r[$];
  logic [3:0] q_b[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  ddr_cmd_monitor #(.T_RC(12)) u0 (
    .clk(clk), .rst(rst), .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .a10_i(a10_i), .ba_i(ba_i),
    .cmd_o(cmd_o), .bank_active_o(bank_active_o), .viol_o(viol_o), .reason_o(reason_o)
  );

  function automatic logic [3:0] pins_of(input logic [3:0] c);
    case (c)
      CMD_DESEL:         return 4'b1111;
      CMD_MRS, CMD_EMRS: return 4'b0000;
      CMD_ACT:           return 4'b0011;
      CMD_RD, CMD_RDA:   return 4'b0101;
      CMD_WR, CMD_WRA:   return 4'b0100;
      CMD_PRE, CMD_PREA: return 4'b0010;
      CMD_BST:           return 4'b0110;
      CMD_REF:           return 4'b0001;
      default:           return 4'b0111;
    endcase
  endfunction

  task automatic drive(input logic k, input logic [3:0] pin_cmd, input logic [1:0] b,
                       input logic [3:0] ecmd, input logic ev, input logic [3:0] er,
                       input string tag);
    @(negedge clk);
    cke_i = k;
    {cs_n_i, ras_n_i, cas_n_i, we_n_i} = pins_of(pin_cmd);
    a10_i = (pin_cmd == CMD_RDA) || (pin_cmd == CMD_WRA) || (pin_cmd == CMD_PREA);
    ba_i = b;
    if (ev) last_r = er;
    q_cmd.push_back(ecmd);
    q_v.push_back(ev);
    q_r.push_back(last_r);
    q_b.push_back(bk);
    q_tag.push_back(tag);
  endtask

  task automatic send(input logic [3:0] c, input logic [1:0] b, input logic ev,
                      input logic [3:0] er, input string tag);
    drive(1'b1, c, b, c, ev, er, tag);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) send(CMD_NOP, 2'd0, 1'b0, 4'd0, "R2 idle cycle");
  endtask

  always @(posedge clk) begin
    #2;
    if (q_cmd.size() > 0) begin
      logic [3:0] ec, er, eb;
      logic ev;
      string t;
      ec = q_cmd.pop_front(); ev = q_v.pop_front(); er = q_r.pop_front();
      eb = q_b.pop_front(); t = q_tag.pop_front();
      checks++;
      if (cmd_o !== ec || viol_o !== ev || reason_o !== er || bank_active_o !== eb) begin
        fails++;
        $display("FAIL %s: cmd %0d exp %0d, viol %0d exp %0d, reason %0d exp %0d, banks %b exp %b",
                 t, cmd_o, ec, viol_o, ev, reason_o, er, bank_active_o, eb);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (cmd_o !== 4'd0 || viol_o !== 1'b0 || reason_o !== 4'd0 || bank_active_o !== 4'd0) begin
      fails++;
      $display("FAIL R2 reset: cmd %0d viol %0d reason %0d banks %b exp all 0",
               cmd_o, viol_o, reason_o, bank_active_o);
    end
    rst = 1'b0;
    @(negedge clk);

    bk = 4'b0001; send(CMD_ACT, 2'd0, 0, 0, "R1 activate bank0");
    send(CMD_ACT, 2'd1, 1, RSN_RRD, "R6 activate within tRRD");
    bk = 4'b0011; send(CMD_ACT, 2'd1, 0, 0, "R6 activate at tRRD");
    send(CMD_RD, 2'd1, 1, RSN_RCD, "R6 read before tRCD");
    send(CMD_RD, 2'd0, 0, 0, "R1 read at tRCD");
    send(CMD_PRE, 2'd0, 1, RSN_RAS, "R7 precharge before tRAS");
    bk = 4'b0010; send(CMD_PRE, 2'd0, 0, 0, "R8 precharge at tRAS");
    send(CMD_ACT, 2'd0, 1, RSN_LOCK, "R8 activate inside tRP");
    nops(1);
    send(CMD_ACT, 2'd0, 1, RSN_RC, "R7 activate before tRC");
    nops(2);
    bk = 4'b0011; send(CMD_ACT, 2'd0, 0, 0, "R7 activate at tRC");
    send(CMD_ACT, 2'd0, 1, RSN_OPEN, "R4 R5 activate open bank, priority");
    send(CMD_RD, 2'd2, 1, RSN_IDLE, "R5 read closed bank");
    bk = 4'b0001; send(CMD_WRA, 2'd1, 0, 0, "R1 write auto-precharge");
    send(CMD_ACT, 2'd1, 1, RSN_LOCK, "R10 activate in write lockout");
    nops(5);
    send(CMD_RD, 2'd1, 1, RSN_LOCK, "R10 last lockout cycle");
    bk = 4'b0011; send(CMD_ACT, 2'd1, 0, 0, "R10 activate after lockout");
    bk = 4'b0010; send(CMD_RDA, 2'd0, 0, 0, "R1 read auto-precharge");
    nops(3);
    send(CMD_PRE, 2'd0, 1, RSN_LOCK, "R9 last read lockout cycle");
    bk = 4'b0011; send(CMD_ACT, 2'd0, 0, 0, "R9 activate after read lockout");
    send(CMD_PREA, 2'd3, 1, RSN_RAS, "R7 all-bank precharge before tRAS");
    nops(4);
    bk = 4'b0000; send(CMD_PREA, 2'd2, 0, 0, "R8 all-bank precharge ignores bank");
    send(CMD_REF, 2'd0, 1, RSN_REFRDY, "R11 refresh while precharging");
    send(CMD_MRS, 2'd0, 1, RSN_MRSRDY, "R12 mode set while precharging");
    send(CMD_REF, 2'd0, 0, 0, "R11 refresh accepted");
    nops(1);
    send(CMD_ACT, 2'd2, 1, RSN_RFC, "R11 activate inside tRFC");
    nops(6);
    send(CMD_MRS, 2'd0, 1, RSN_RFC, "R11 last tRFC cycle");
    send(CMD_MRS, 2'd0, 0, 0, "R12 mode set accepted");
    send(CMD_ACT, 2'd3, 1, RSN_MRD, "R12 activate inside tMRD");
    send(CMD_EMRS, 2'd1, 0, 0, "R1 extended mode set");
    send(CMD_BST, 2'd0, 1, RSN_MRD, "R12 burst stop inside tMRD");
    send(CMD_BST, 2'd0, 0, 0, "R1 burst stop");
    drive(1'b0, CMD_ACT, 2'd3, CMD_CKE, 0, 0, "R1 clock enable low");
    drive(1'b1, CMD_ACT, 2'd3, CMD_CKE, 0, 0, "R1 clock enable was low");
    send(CMD_DESEL, 2'd3, 0, 0, "R1 deselect");
    bk = 4'b1000; send(CMD_ACT, 2'd3, 0, 0, "R1 activate bank3");
    nops(1);
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule